// File: doc/BRIEF.md
# Core-Local Interrupt Arbiter

This block sits next to a single processor core. It gathers a parameterised number of interrupt lines and keeps a small group of byte registers for each line: a pending flag, an enable flag, an attribute byte and a control byte. It also has a global configuration byte, a read-only capability word and a threshold byte. Each line passes through a two-stage synchronizer. It can then be treated as level-sensitive or as sensitive to a rising or a falling edge.

Each cycle, the block compares every line that is both enabled and pending. The winner is the line with the highest interrupt level, then the highest priority, and then the lowest line number. The block presents the winner's number, level and vectoring flag to the core. A request is raised only when the winner's level is strictly above the threshold.

The control byte is split at run time. The configuration byte sets how many of its top bits form the level. The implemented bits below the level form the priority, and the unimplemented low bits always read as one.

The interrupt side is a presentation plus an acknowledge, with no ready signal. `irq_valid`, `irq_id`, `irq_level` and `irq_shv` reflect the current winner every cycle and stay put for as long as that winner is unchanged. The core may stall indefinitely without losing anything. The core answers with `irq_ack` and `ack_id`. This clears the pending flag of that line if it is edge-triggered. An acknowledge does not need `irq_valid` to be high. Register reads are combinational and have no side effects. Writes take effect at the clock edge on which `reg_we` is high.

Top module: `clic_arbiter`

## Requirements
- R1: Source i owns four bytes at SRC_BASE+4*i in this order: offset 0 pending (bit 0), offset 1 enable (bit 0), offset 2 attribute, offset 3 control. The configuration byte is at 0x000, the capability word at 0x004..0x007 (least significant byte first) and the threshold at 0x008. Every other address reads zero, and writes to it are ignored.
- R2: In the attribute byte, bit 0 is the vectoring flag. Bits [2:1] are the trigger: 0 level, 1 rising edge, 2 falling edge, and 3 behaves as falling edge. Bits [7:3] read zero.
- R3: In the configuration byte, bits [4:1] hold the level width nl. The other bits read zero.
- R4: The capability word reads NSRC in bits [12:0], VERSION in bits [20:13] and CTL_BITS in bits [24:21], with zero above.
- R5: The top CTL_BITS bits of a control byte store the written value. The bits below them always read one.
- R6: After reset, the pending, enable and attribute bytes and the configuration and threshold bytes read zero, each control byte reads only its forced-one bits, and irq_valid is low.
- R7: For a level-triggered source, pending equals the input as seen three clock edges earlier. Software writes to its pending bit have no effect.
- R8: For an edge-triggered source, the selected input edge sets pending. It stays set after the input returns. A software write of 1 sets pending and a write of 0 clears it.
- R9: irq_ack with ack_id = i clears the pending bit of edge-triggered source i on that clock edge. It leaves level-triggered sources untouched.
- R10: Only sources that are both enabled and pending compete. The winner has the largest control byte, which orders by level then by priority. On equal control bytes the lowest source number wins.
- R11: irq_level is the winner's control byte with every bit below the top min(nl,8) bits forced to one. Priority bits therefore never change it.
- R12: irq_valid is high exactly when a winner exists and its irq_level is strictly greater than the threshold byte.
- R13: While irq_valid is high, irq_id is the winner's number and irq_shv is its vectoring flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | Raw interrupt lines, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data at reg_addr |
| irq_valid | output | 1 | Request to the core |
| irq_id | output | ID_W | Winning source number |
| irq_level | output | 8 | Winning interrupt level |
| irq_shv | output | 1 | Winner wants hardware vectoring |
| irq_ack | input | 1 | Core acknowledges a source |
| ack_id | input | ID_W | Source being acknowledged |

## Verification
The control byte is swept through all 256 written values, which separates stored bits from forced-one bits. Each trigger kind gets its own input waveform: a level held and then dropped, a rising pulse, and a falling pulse. These patterns tell following from latching, and the right edge from the wrong one, and they show which sources react to software writes and acknowledges. Arbitration is tried on every combination of pending and enable masks over four sources. This is done under four control, level-width and threshold sets chosen so that levels tie while priorities differ, priorities tie, all bytes tie, and the threshold cuts some winners. These sets tell level-first ordering from plain priority and lowest-number tie breaking from any other order, and they test the strict threshold compare.

// File: rtl/clic_pkg.sv
package clic_pkg;

  typedef enum logic [1:0] {
    TRG_LEVEL = 2'd0,
    TRG_RISE  = 2'd1,
    TRG_FALL  = 2'd2,
    TRG_FALL2 = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    GB_PEND = 2'd0,
    GB_EN   = 2'd1,
    GB_ATTR = 2'd2,
    GB_CTRL = 2'd3
  } grp_byte_e;

  // Level value: control byte with everything below the top nl bits set.
  function automatic logic [7:0] level_of(input logic [7:0] ctrl, input logic [3:0] nl);
    logic [3:0] n;
    n = (nl > 4'd8) ? 4'd8 : nl;
    return ctrl | (8'hFF >> n);
  endfunction

endpackage

// File: rtl/clic_sync.sv
module clic_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/clic_source.sv
module clic_source
  import clic_pkg::*;
#(
  parameter int CTL_BITS = 4,
  localparam logic [7:0] LOW_ONES = 8'hFF >> CTL_BITS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic       wr_en,
  input  grp_byte_e  wr_byte,
  input  logic [7:0] wr_data,
  input  logic       ack_hit,
  output logic       pend,
  output logic       enable,
  output logic       shv,
  output trig_e      trig,
  output logic [7:0] ctrl
);
  logic       prev_q;
  logic       edge_seen;
  logic [7:0] ctrl_q;

  always_comb begin
    unique case (trig)
      TRG_LEVEL: edge_seen = 1'b0;
      TRG_RISE:  edge_seen = sync_in & ~prev_q;
      default:   edge_seen = ~sync_in & prev_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
      enable <= 1'b0;
      shv    <= 1'b0;
      trig   <= TRG_LEVEL;
      ctrl_q <= 8'h00;
    end else begin
      prev_q <= sync_in;
      if (trig == TRG_LEVEL)                pend <= sync_in;
      else if (edge_seen)                   pend <= 1'b1;
      else if (wr_en && wr_byte == GB_PEND) pend <= wr_data[0];
      else if (ack_hit)                     pend <= 1'b0;
      if (wr_en && wr_byte == GB_EN) enable <= wr_data[0];
      if (wr_en && wr_byte == GB_ATTR) begin
        shv  <= wr_data[0];
        trig <= trig_e'(wr_data[2:1]);
      end
      if (wr_en && wr_byte == GB_CTRL) ctrl_q <= wr_data & ~LOW_ONES;
    end
  end

  assign ctrl = ctrl_q | LOW_ONES;
endmodule

// File: rtl/clic_select.sv
module clic_select #(
  parameter int N    = 8,
  parameter int ID_W = 3
) (
  input  logic [N-1:0]      cand,
  input  logic [N-1:0][7:0] key,
  output logic              found,
  output logic [ID_W-1:0]   win_id,
  output logic [7:0]        win_key
);
  // Strictly-greater replacement while scanning upward keeps the lowest ID on ties.
  always_comb begin
    found   = 1'b0;
    win_id  = '0;
    win_key = 8'h00;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || key[i] > win_key)) begin
        found   = 1'b1;
        win_id  = ID_W'(i);
        win_key = key[i];
      end
    end
  end
endmodule

// File: rtl/clic_arbiter.sv
module clic_arbiter
  import clic_pkg::*;
#(
  parameter int         NSRC     = 8,
  parameter int         CTL_BITS = 4,
  parameter logic [7:0] VERSION  = 8'h01,
  parameter int         ADDR_W   = 12,
  parameter int         SRC_BASE = 256,
  localparam int        ID_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_valid,
  output logic [ID_W-1:0]   irq_id,
  output logic [7:0]        irq_level,
  output logic              irq_shv,
  input  logic              irq_ack,
  input  logic [ID_W-1:0]   ack_id
);
  localparam logic [ADDR_W-1:0] BASE_A    = ADDR_W'(SRC_BASE);
  localparam logic [ADDR_W-1:0] CFG_A     = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] THR_A     = ADDR_W'(8);
  localparam logic [ADDR_W-3:0] INFO_W    = (ADDR_W-2)'(1);
  localparam logic [31:0]       INFO_WORD = {7'd0, 4'(CTL_BITS), VERSION, 13'(NSRC)};

  logic [NSRC-1:0]      sync_v;
  logic [NSRC-1:0]      pend_v;
  logic [NSRC-1:0]      en_v;
  logic [NSRC-1:0]      shv_v;
  logic [NSRC-1:0][1:0] trig_a;
  logic [NSRC-1:0][7:0] ctrl_a;
  logic [NSRC-1:0]      cand_v;

  logic [ADDR_W-1:0] src_off;
  logic [ADDR_W-3:0] src_idx;
  logic              src_hit;
  logic [ID_W-1:0]   sel;
  grp_byte_e         grp;

  logic [3:0] nl_q;
  logic [7:0] thr_q;

  logic            found;
  logic [ID_W-1:0] win_id;
  logic [7:0]      win_key;

  // address decode
  assign src_off = reg_addr - BASE_A;
  assign src_idx = src_off[ADDR_W-1:2];
  assign src_hit = (reg_addr >= BASE_A) && ({2'b00, src_idx} < ADDR_W'(NSRC));
  assign sel     = src_idx[ID_W-1:0];
  assign grp     = grp_byte_e'(src_off[1:0]);

  clic_sync #(.N(NSRC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (irq_in),
    .q    (sync_v)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    clic_source #(.CTL_BITS(CTL_BITS)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_in(sync_v[g]),
      .wr_en  (reg_we && src_hit && (src_idx == (ADDR_W-2)'(g))),
      .wr_byte(grp),
      .wr_data(reg_wdata),
      .ack_hit(irq_ack && (ack_id == ID_W'(g))),
      .pend   (pend_v[g]),
      .enable (en_v[g]),
      .shv    (shv_v[g]),
      .trig   (trig_a[g]),
      .ctrl   (ctrl_a[g])
    );
  end

  // global registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nl_q  <= 4'd0;
      thr_q <= 8'd0;
    end else if (reg_we) begin
      if (reg_addr == CFG_A) nl_q  <= reg_wdata[4:1];
      if (reg_addr == THR_A) thr_q <= reg_wdata;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = 8'h00;
    if (src_hit) begin
      unique case (grp)
        GB_PEND: reg_rdata = {7'd0, pend_v[sel]};
        GB_EN:   reg_rdata = {7'd0, en_v[sel]};
        GB_ATTR: reg_rdata = {5'd0, trig_a[sel], shv_v[sel]};
        default: reg_rdata = ctrl_a[sel];
      endcase
    end else if (reg_addr == CFG_A) begin
      reg_rdata = {3'd0, nl_q, 1'b0};
    end else if (reg_addr == THR_A) begin
      reg_rdata = thr_q;
    end else if (reg_addr[ADDR_W-1:2] == INFO_W) begin
      unique case (reg_addr[1:0])
        2'd0:    reg_rdata = INFO_WORD[7:0];
        2'd1:    reg_rdata = INFO_WORD[15:8];
        2'd2:    reg_rdata = INFO_WORD[23:16];
        default: reg_rdata = INFO_WORD[31:24];
      endcase
    end
  end

  // arbitration
  assign cand_v = pend_v & en_v;

  clic_select #(.N(NSRC), .ID_W(ID_W)) u_sel (
    .cand   (cand_v),
    .key    (ctrl_a),
    .found  (found),
    .win_id (win_id),
    .win_key(win_key)
  );

  assign irq_level = level_of(win_key, nl_q);
  assign irq_valid = found && (irq_level > thr_q);
  assign irq_id    = win_id;
  assign irq_shv   = shv_v[win_id];
endmodule

// File: rtl/clic_arbiter_chk.sv
module clic_arbiter_chk #(
  parameter int NSRC     = 8,
  parameter int CTL_BITS = 4,
  parameter int ID_W     = 3,
  parameter int ADDR_W   = 12,
  parameter int SRC_BASE = 256
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [7:0]           reg_rdata,
  input logic                 irq_valid,
  input logic [ID_W-1:0]      irq_id,
  input logic [NSRC-1:0]      pend_v,
  input logic [NSRC-1:0]      en_v,
  input logic [NSRC-1:0][7:0] ctrl_a,
  input logic [NSRC-1:0][1:0] trig_a,
  input logic [NSRC-1:0]      sync_v
);
  localparam logic [7:0]        LOW  = 8'hFF >> CTL_BITS;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(SRC_BASE);

  logic [ADDR_W-1:0] off;
  logic              in_src;
  assign off    = reg_addr - BASE;
  assign in_src = (reg_addr >= BASE) && ((off >> 2) < ADDR_W'(NSRC));

  // R5: forced-one bits seen at the read port
  p_ctrl_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_src && reg_addr[1:0] == 2'd3) |-> ((reg_rdata & LOW) == LOW));

  // R2: reserved attribute bits read zero
  p_attr_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_src && reg_addr[1:0] == 2'd2) |-> (reg_rdata[7:3] == 5'd0));

  // R10: the presented source is enabled and pending
  p_winner_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (pend_v[irq_id] && en_v[irq_id]));

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R10: no competitor beats the winner
    p_no_better_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && pend_v[i] && en_v[i]) |-> (ctrl_a[i] <= ctrl_a[irq_id]));
    // R10: ties resolve toward the lower number
    p_tie_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && pend_v[i] && en_v[i] && ctrl_a[i] == ctrl_a[irq_id])
        |-> (irq_id <= ID_W'(i)));
    // R7: level-mode pending tracks the synchronized line
    p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_a[i] == 2'd0) |=> (pend_v[i] == $past(sync_v[i])));
  end
endmodule

bind clic_arbiter clic_arbiter_chk #(
  .NSRC(NSRC), .CTL_BITS(CTL_BITS), .ID_W(ID_W), .ADDR_W(ADDR_W), .SRC_BASE(SRC_BASE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .irq_valid(irq_valid),
  .irq_id   (irq_id),
  .pend_v   (pend_v),
  .en_v     (en_v),
  .ctrl_a   (ctrl_a),
  .trig_a   (trig_a),
  .sync_v   (sync_v)
);

// File: tb/tb_clic_arbiter.sv
module tb_clic_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 4;
  localparam int CB   = 4;
  localparam int AW   = 12;
  localparam int BASE = 256;
  localparam int IDW  = 2;
  localparam logic [7:0] VER = 8'h21;
  localparam int WATCHDOG = 200000;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NS-1:0]  irq_in;
  logic           reg_we;
  logic [AW-1:0]  reg_addr;
  logic [7:0]     reg_wdata;
  logic [7:0]     reg_rdata;
  logic           irq_valid;
  logic [IDW-1:0] irq_id;
  logic [7:0]     irq_level;
  logic           irq_shv;
  logic           irq_ack;
  logic [IDW-1:0] ack_id;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clic_arbiter #(
    .NSRC(NS), .CTL_BITS(CB), .VERSION(VER), .ADDR_W(AW), .SRC_BASE(BASE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_level(irq_level),
    .irq_shv(irq_shv), .irq_ack(irq_ack), .ack_id(ack_id)
  );

  function automatic logic [AW-1:0] sa(input int i, input int k);
    return AW'(BASE + 4*i + k);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(input int id);
    @(negedge clk);
    irq_ack = 1'b1; ack_id = IDW'(id);
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [31:0] info;
    logic [7:0] cset [4][NS];
    logic [3:0] nlset [4];
    logic [7:0] thset [4];

    rst_n = 1'b0; irq_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    irq_ack = 1'b0; ack_id = '0;
    wait_n(3);
    rst_n = 1'b1;

    // R6 / R5: reset values
    check("R6 irq_valid", 32'(irq_valid), 0);
    for (int i = 0; i < NS; i++) begin
      rd(sa(i, 0), d); check("R6 pend", 32'(d), 0);
      rd(sa(i, 1), d); check("R6 en", 32'(d), 0);
      rd(sa(i, 2), d); check("R6 attr", 32'(d), 0);
      rd(sa(i, 3), d); check("R5 ctrl reset", 32'(d), 32'h0F);
    end
    rd(AW'(0), d); check("R6 cfg", 32'(d), 0);
    rd(AW'(8), d); check("R6 thr", 32'(d), 0);

    // R4: capability word
    info = 0;
    for (int k = 0; k < 4; k++) begin
      rd(AW'(4 + k), d);
      info[8*k +: 8] = d;
    end
    check("R4 info", info, {7'd0, 4'd4, VER, 13'd4});

    // R3, R2, R1
    wr(AW'(0), 8'hFF); rd(AW'(0), d); check("R3 cfg mask", 32'(d), 32'h1E);
    wr(AW'(0), 8'h00);
    wr(sa(1, 2), 8'hFF); rd(sa(1, 2), d); check("R2 attr mask", 32'(d), 32'h07);
    wr(sa(1, 2), 8'h00);
    wr(AW'(8), 8'h5A); rd(AW'(8), d); check("R1 thr", 32'(d), 32'h5A);
    wr(AW'(8), 8'h00);
    wr(AW'(12), 8'hAA); rd(AW'(12), d); check("R1 unmapped", 32'(d), 0);
    wr(sa(NS, 3), 8'hAA); rd(sa(NS, 3), d); check("R1 past end", 32'(d), 0);
    rd(sa(NS - 1, 3), d); check("R1 last ctrl untouched", 32'(d), 32'h0F);

    // R5: control byte sweep
    for (int v = 0; v < 256; v++) begin
      wr(sa(2, 3), 8'(v)); rd(sa(2, 3), d);
      check("R5 ctrl sweep", 32'(d), 32'(v | 8'h0F));
    end
    wr(sa(2, 3), 8'h00);

    // R7: level trigger on source 0
    wr(sa(0, 1), 8'h01);
    irq_in[0] = 1'b1; wait_n(4);
    rd(sa(0, 0), d); check("R7 level set", 32'(d), 1);
    check("R13 valid level", 32'(irq_valid), 1);
    check("R13 id level", 32'(irq_id), 0);
    wr(sa(0, 0), 8'h00); rd(sa(0, 0), d); check("R7 sw clear ignored", 32'(d), 1);
    ack(0); rd(sa(0, 0), d); check("R9 ack on level ignored", 32'(d), 1);
    irq_in[0] = 1'b0; wait_n(4);
    rd(sa(0, 0), d); check("R7 level drop", 32'(d), 0);
    check("R12 no request", 32'(irq_valid), 0);
    wr(sa(0, 0), 8'h01); rd(sa(0, 0), d); check("R7 sw set ignored", 32'(d), 0);

    // R8 / R9: rising edge on source 1
    wr(sa(1, 2), 8'h02); wr(sa(1, 1), 8'h01);
    irq_in[1] = 1'b1; wait_n(4);
    rd(sa(1, 0), d); check("R8 rise set", 32'(d), 1);
    irq_in[1] = 1'b0; wait_n(4);
    rd(sa(1, 0), d); check("R8 rise held", 32'(d), 1);
    check("R13 id edge", 32'(irq_id), 1);
    ack(2); rd(sa(1, 0), d); check("R9 other ack", 32'(d), 1);
    ack(1); rd(sa(1, 0), d); check("R9 ack clear", 32'(d), 0);
    check("R9 valid after ack", 32'(irq_valid), 0);
    wr(sa(1, 0), 8'h01); rd(sa(1, 0), d); check("R8 sw set", 32'(d), 1);
    wr(sa(1, 0), 8'h00); rd(sa(1, 0), d); check("R8 sw clear", 32'(d), 0);

    // R8 / R2: falling edge on source 2 (code 2) and source 3 (code 3)
    wr(sa(2, 2), 8'h04); wr(sa(3, 2), 8'h06);
    irq_in[3:2] = 2'b11; wait_n(4);
    rd(sa(2, 0), d); check("R8 fall ignores rise", 32'(d), 0);
    rd(sa(3, 0), d); check("R2 code3 ignores rise", 32'(d), 0);
    irq_in[3:2] = 2'b00; wait_n(4);
    rd(sa(2, 0), d); check("R8 fall set", 32'(d), 1);
    rd(sa(3, 0), d); check("R2 code3 fall set", 32'(d), 1);

    // R10-R13: arbitration sweep; all sources edge mode, pending set by software
    cset[0] = '{8'h5F, 8'h9F, 8'h9F, 8'h3F}; nlset[0] = 4'd2;  thset[0] = 8'h00;
    cset[1] = '{8'h1F, 8'h8F, 8'h2F, 8'h8F}; nlset[1] = 4'd0;  thset[1] = 8'hFE;
    cset[2] = '{8'hFF, 8'h3F, 8'hFF, 8'h7F}; nlset[2] = 4'd4;  thset[2] = 8'h7F;
    cset[3] = '{8'h0F, 8'h0F, 8'h0F, 8'h0F}; nlset[3] = 4'd15; thset[3] = 8'h0E;
    for (int i = 0; i < NS; i++) wr(sa(i, 2), (i % 2 == 1) ? 8'h03 : 8'h02);
    for (int s = 0; s < 4; s++) begin
      wr(AW'(0), {3'd0, nlset[s], 1'b0});
      wr(AW'(8), thset[s]);
      for (int i = 0; i < NS; i++) wr(sa(i, 3), cset[s][i]);
      for (int m = 0; m < 256; m++) begin
        logic found;
        logic [7:0] best;
        int wid;
        logic [7:0] lvl;
        logic expv;
        int n;
        for (int i = 0; i < NS; i++) begin
          wr(sa(i, 0), {7'd0, m[i]});
          wr(sa(i, 1), {7'd0, m[4+i]});
        end
        found = 1'b0; best = 8'h00; wid = 0;
        for (int i = 0; i < NS; i++) begin
          if (m[i] && m[4+i] && (!found || cset[s][i] > best)) begin
            found = 1'b1; best = cset[s][i]; wid = i;
          end
        end
        n = (nlset[s] > 8) ? 8 : int'(nlset[s]);
        lvl = best | 8'(8'hFF >> n);
        expv = found && (lvl > thset[s]);
        #1;
        check("R12 valid", 32'(irq_valid), 32'(expv));
        if (expv) begin
          check("R10 winner id", 32'(irq_id), 32'(wid));
          check("R11 level", 32'(irq_level), 32'(lvl));
          check("R13 shv", 32'(irq_shv), 32'(wid % 2));
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule